// File: doc/BRIEF.md
# CAN transceiver mode and wakeup controller

This block is the digital mode and wakeup logic of a high-speed CAN transceiver. A mode-request input chooses between an active operating mode (Normal) and a low-power mode (Standby). The analog bus comparators are outside the block. The state of the bus reaches it as one digital flag that is high while the bus is dominant. In Normal mode the receive output follows the bus. The transmitter, the main receiver and the common-mode split source are enabled.

In Standby those three enables are off. The bus flag then comes from a low-power monitor and passes through a wakeup filter. A dominant level that lasts the full filter time pulls the receive output low. The indication is not held: it clears once the bus has been recessive for the same filter time. Leaving Standby takes a programmable delay, and raising the request again during that delay cancels it. A build-time parameter selects one of two wakeup variants. The first reacts to a dominant level that is already on the bus when Standby is entered. The second ignores that level until the bus has gone recessive once.

All timings are counts of clock cycles. The bus flag passes through a two-flop synchronizer first. Reset is synchronous and active high, and puts the block in Standby.

Top module: `can_xcvr_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it is released, the block is in Standby: `rx_out` is 1 and `tx_en`, `rx_main_en` and `split_en` are 0.
- R2: `stby_req` = 1 requests Standby. If it is sampled high in Normal mode, all three enables read 0 two cycles later.
- R3: `stby_req` = 0 requests Normal. The enables rise WAKE_DLY_CYC+2 cycles after the request is first sampled low, and are still low one cycle earlier. If `stby_req` returns high before the delay ends, the enables never rise.
- R4: In Normal mode, `bus_dom` = 1 means dominant. `rx_out` equals the inverse of `bus_dom` with a latency of three cycles.
- R5: In Standby, `rx_out` goes low only when `bus_dom` has been 1 for at least FILT_CYC consecutive cycles. It goes low FILT_CYC+3 cycles after the dominant level starts.
- R6: The wakeup indication is not held. `rx_out` returns to 1 FILT_CYC+3 cycles after `bus_dom` returns to 0. A dominant pulse shorter than FILT_CYC cycles leaves `rx_out` at 1 throughout.
- R7: With FAULT_TOL = 0, suppose the bus is dominant when Standby is requested. `rx_out` reads 1 from the second cycle after the request, then 0 from cycle FILT_CYC+2 onward.
- R8: With FAULT_TOL = 1, a dominant level present at Standby entry never causes a wakeup. After the bus has been recessive, a new dominant level of at least FILT_CYC cycles wakes the node, with the timing of R5.
- R9: `split_en`, `tx_en` and `rx_main_en` are 1 only in Normal mode. They stay 0 throughout Standby, including during the exit delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stby_req | input | 1 | 1 = Standby request, 0 = Normal request |
| bus_dom | input | 1 | Bus state from the comparators, 1 = dominant (asynchronous) |
| rx_out | output | 1 | Receive data / wakeup output, low = dominant or wakeup |
| tx_en | output | 1 | Transmitter enable |
| rx_main_en | output | 1 | Main receiver enable |
| split_en | output | 1 | Common-mode split source enable |

## Verification
The assertions check on every cycle the following properties:
- A Standby request reaches the mode state one cycle later.
- Normal mode is entered only from the exit delay, with the request low.
- In Normal mode `rx_out` tracks the synchronized bus.
- The enables are off outside Normal mode.
- A wakeup begins only on a dominant sample and ends only on a recessive sample or on leaving Standby.
- The filter counter never passes its limit.
- A disarmed filter never reports a wakeup.

The exact cycle counts can only be shown by the bench's scenarios. These are the filter threshold at FILT_CYC-1 and FILT_CYC cycles, the release time, the exit delay and its cancellation, and the different handling of a dominant level at Standby entry by the two variants.

// File: rtl/can_xcvr_pkg.sv
package can_xcvr_pkg;
  typedef enum logic [1:0] {
    MODE_STBY   = 2'd0,
    MODE_WAKING = 2'd1,
    MODE_NORM   = 2'd2
  } mode_e;
endpackage

// File: rtl/can_bus_sync.sv
module can_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sr;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) sr[g] <= 1'b0;
      else if (g == 0) sr[g] <= din;
      else sr[g] <= sr[(g == 0) ? 0 : g-1];
    end
  end

  assign dout = sr[STAGES-1];
endmodule

// File: rtl/can_mode_fsm.sv
module can_mode_fsm
  import can_xcvr_pkg::*;
#(
  parameter int WAKE_DLY_CYC = 750
) (
  input  logic clk,
  input  logic rst,
  input  logic stby_req,
  output logic norm
);
  localparam int DW = $clog2(WAKE_DLY_CYC + 1);
  localparam logic [DW-1:0] DMAX = DW'(WAKE_DLY_CYC - 1);

  mode_e          mode_q, mode_n;
  logic [DW-1:0]  dly_cnt;

  always_comb begin
    mode_n = mode_q;
    case (mode_q)
      MODE_STBY:   if (!stby_req) mode_n = MODE_WAKING;
      MODE_WAKING: begin
        if (stby_req) mode_n = MODE_STBY;
        else if (dly_cnt == DMAX) mode_n = MODE_NORM;
      end
      MODE_NORM:   if (stby_req) mode_n = MODE_STBY;
      default:     mode_n = MODE_STBY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= MODE_STBY;
      dly_cnt <= '0;
    end else begin
      mode_q  <= mode_n;
      dly_cnt <= (mode_q == MODE_WAKING) ? dly_cnt + 1'b1 : '0;
    end
  end

  assign norm = (mode_q == MODE_NORM);

  // R2
  stby_entry_chk: assert property (@(posedge clk) disable iff (rst)
    stby_req |=> mode_q == MODE_STBY);

  // R3
  norm_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(norm) |-> ($past(mode_q) == MODE_WAKING) && !$past(stby_req));
endmodule

// File: rtl/can_wake_filter.sv
module can_wake_filter #(
  parameter int FILT_CYC  = 250,
  parameter bit FAULT_TOL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic bus_s,
  output logic wake_q
);
  localparam int FW = $clog2(FILT_CYC + 1);
  localparam logic [FW-1:0] CMAX = FW'(FILT_CYC - 1);

  logic          armed_q;
  logic [FW-1:0] dom_cnt;
  logic [FW-1:0] rec_cnt;
  logic          dom_full;
  logic          rec_full;

  assign dom_full = armed_q && bus_s && (dom_cnt == CMAX);
  assign rec_full = wake_q && !bus_s && (rec_cnt == CMAX);

  always_ff @(posedge clk) begin
    if (rst || !active)   armed_q <= !FAULT_TOL;
    else if (!bus_s)      armed_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || !active || !bus_s || !armed_q) dom_cnt <= '0;
    else if (dom_cnt != CMAX)                 dom_cnt <= dom_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || !active || !wake_q || bus_s) rec_cnt <= '0;
    else if (rec_cnt != CMAX)               rec_cnt <= rec_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || !active) wake_q <= 1'b0;
    else if (dom_full)  wake_q <= 1'b1;
    else if (rec_full)  wake_q <= 1'b0;
  end

  // R5
  wake_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wake_q) |-> $past(bus_s) && $past(armed_q));

  // R6
  wake_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(wake_q) |-> !$past(bus_s) || !$past(active));

  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    dom_cnt <= CMAX && rec_cnt <= CMAX);

  // R8
  disarmed_chk: assert property (@(posedge clk) disable iff (rst)
    !armed_q |-> !wake_q);
endmodule

// File: rtl/can_xcvr_ctrl.sv
module can_xcvr_ctrl #(
  parameter int SYNC_STAGES  = 2,
  parameter int FILT_CYC     = 250,
  parameter int WAKE_DLY_CYC = 750,
  parameter bit FAULT_TOL    = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic stby_req,
  input  logic bus_dom,
  output logic rx_out,
  output logic tx_en,
  output logic rx_main_en,
  output logic split_en
);
  logic bus_s;
  logic norm;
  logic wake;

  can_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(bus_dom), .dout(bus_s)
  );

  can_mode_fsm #(.WAKE_DLY_CYC(WAKE_DLY_CYC)) u_mode (
    .clk(clk), .rst(rst), .stby_req(stby_req), .norm(norm)
  );

  can_wake_filter #(.FILT_CYC(FILT_CYC), .FAULT_TOL(FAULT_TOL)) u_filt (
    .clk(clk), .rst(rst), .active(!norm), .bus_s(bus_s), .wake_q(wake)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_out     <= 1'b1;
      tx_en      <= 1'b0;
      rx_main_en <= 1'b0;
      split_en   <= 1'b0;
    end else begin
      rx_out     <= norm ? !bus_s : !wake;
      tx_en      <= norm;
      rx_main_en <= norm;
      split_en   <= norm;
    end
  end

  // R4
  rx_follow_chk: assert property (@(posedge clk) disable iff (rst)
    norm |=> rx_out == !$past(bus_s));

  // R9
  en_off_chk: assert property (@(posedge clk) disable iff (rst)
    !norm |=> !split_en && !tx_en && !rx_main_en);
endmodule

// File: tb/can_xcvr_ctrl_tb.sv
module can_xcvr_ctrl_tb;
  localparam int FILT = 6;
  localparam int DLY  = 10;

  logic clk = 1'b0;
  logic rst, stby, bus;
  logic rx_u, tx_u, rxe_u, spl_u;
  logic rx_f, tx_f, rxe_f, spl_f;
  int   nchk = 0;
  int   nerr = 0;
  bit   done = 1'b0;
  logic hist [0:63];

  always #5 clk = ~clk;

  can_xcvr_ctrl #(.FILT_CYC(FILT), .WAKE_DLY_CYC(DLY), .FAULT_TOL(1'b0)) u_dut (
    .clk(clk), .rst(rst), .stby_req(stby), .bus_dom(bus),
    .rx_out(rx_u), .tx_en(tx_u), .rx_main_en(rxe_u), .split_en(spl_u)
  );

  can_xcvr_ctrl #(.FILT_CYC(FILT), .WAKE_DLY_CYC(DLY), .FAULT_TOL(1'b1)) u_dut_ft (
    .clk(clk), .rst(rst), .stby_req(stby), .bus_dom(bus),
    .rx_out(rx_f), .tx_en(tx_f), .rx_main_en(rxe_f), .split_en(spl_f)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk_en(input string tag, input logic exp);
    chk(tag, spl_u, exp); chk(tag, tx_u, exp); chk(tag, rxe_u, exp);
    chk(tag, spl_f, exp); chk(tag, tx_f, exp); chk(tag, rxe_f, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++;
      nchk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; stby = 1'b1; bus = 1'b0;
    repeat (3) tick();
    chk("R1 rx in reset", rx_u, 1'b1);
    chk_en("R1 enables in reset", 1'b0);
    rst = 1'b0;
    tick();
    chk("R1 rx after reset", rx_u, 1'b1);
    chk("R1 rx after reset ft", rx_f, 1'b1);
    chk_en("R1 enables after reset", 1'b0);
    repeat (4) tick();

    // R5 / R6: sweep of dominant pulse lengths in Standby
    for (int len = 1; len <= FILT + 2; len++) begin
      bus = 1'b1;
      for (int k = 1; k <= len + FILT + 5; k++) begin
        logic exp;
        tick();
        exp = !(len >= FILT && k >= FILT + 3 && k < len + FILT + 3);
        chk((len >= FILT) ? "R5 wake timing" : "R6 short pulse ignored", rx_u, exp);
        chk("R6 release timing ft", rx_f, exp);
        chk_en("R9 enables off in standby", 1'b0);
        if (k == len) bus = 1'b0;
      end
      repeat (3) tick();
    end

    // R3: exit delay cancelled by a renewed request
    stby = 1'b0;
    repeat (DLY / 2) tick();
    stby = 1'b1;
    for (int k = 1; k <= DLY + 4; k++) begin
      tick();
      chk_en("R3 cancelled exit", 1'b0);
    end

    // R3: full exit delay
    stby = 1'b0;
    for (int k = 1; k <= DLY + 3; k++) begin
      tick();
      chk_en("R3 exit delay", (k >= DLY + 2) ? 1'b1 : 1'b0);
    end

    // R4: Normal mode follows the bus with three cycles of latency
    for (int i = 0; i < 48; i++) begin
      tick();
      if (i >= 3) begin
        chk("R4 rx follows bus", rx_u, !hist[i-3]);
        chk("R4 rx follows bus ft", rx_f, !hist[i-3]);
      end
      hist[i] = (((i * 5) + (i >> 2)) % 3) == 0;
      bus = hist[i];
    end

    // R7 / R8: Standby entry while the bus is dominant
    bus = 1'b1;
    repeat (5) tick();
    chk("R4 dominant in normal", rx_u, 1'b0);
    stby = 1'b1;
    for (int k = 1; k <= FILT + 6; k++) begin
      tick();
      chk("R7 unconditioned wake", rx_u, (k == 1 || k >= FILT + 2) ? 1'b0 : 1'b1);
      chk("R8 initial dominant ignored", rx_f, (k == 1) ? 1'b0 : 1'b1);
      chk("R2 enables drop", spl_u, (k == 1) ? 1'b1 : 1'b0);
      chk("R2 enables drop ft", tx_f, (k == 1) ? 1'b1 : 1'b0);
    end
    bus = 1'b0;
    for (int k = 1; k <= FILT + 5; k++) begin
      tick();
      chk("R6 release after entry wake", rx_u, (k < FILT + 3) ? 1'b0 : 1'b1);
      chk("R8 stays idle on release", rx_f, 1'b1);
    end
    bus = 1'b1;
    for (int k = 1; k <= FILT + 5; k++) begin
      tick();
      chk("R5 fresh dominant", rx_u, (k >= FILT + 3) ? 1'b0 : 1'b1);
      chk("R8 fresh dominant wakes ft", rx_f, (k >= FILT + 3) ? 1'b0 : 1'b1);
      chk_en("R9 enables off", 1'b0);
    end
    bus = 1'b0;
    repeat (FILT + 4) tick();
    chk("R6 idle at end", rx_u, 1'b1);
    chk("R6 idle at end ft", rx_f, 1'b1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule